// File: doc/BRIEF.md
# Serial Transmitter with Break Generation

This block turns bytes written by a host into an asynchronous serial bit stream on one TX line. A frame is a low start bit, then eight or nine data bits with the lowest bit first, then a high stop bit. The host writes into a one-entry holding buffer in front of a shift register. A flag reports when that buffer can take another byte, and an interrupt request can be raised from that flag. The bit rate comes from an external tick: every bit lasts exactly one tick.

The transmitter begins by shifting out one frame's worth of idle ones whenever it is switched on. The flag that reports an empty buffer has a guarded clear: the host must first read the status and then write data. A write that is not preceded by a status read stores nothing that will be sent. The block can also hold the line low with break characters. Each break is as long as a frame in the current mode and repeats while requested. The last break is always followed by at least one high bit. When the block is disabled, it releases the line through an output-enable signal.

Top module: `uart_brk_tx`

## Requirements
- R1: After reset, stat_empty is 1, tx_out is 1, tx_oe is 0 and irq is 0.
- R2: With ctl_wide=0, a frame is 10 bits, one per baud tick: bit 0 is a 0 start bit, bits 1..8 are data_in[0]..data_in[7], and bit 9 is a 1 stop bit.
- R3: With ctl_wide=1, a frame is 11 bits: 0 start bit, data bits 0..7, then ctl_xbit (sampled when the byte leaves the buffer), then a 1 stop bit.
- R4: When ctl_en and ctl_txen both become 1, the line first sends as many ones as a frame has bits (10 or 11). Only then can a buffered frame start.
- R5: stat_empty returns to 1 when the buffered byte moves into the shift register. A byte written during a frame is sent right after it, with no idle bit between.
- R6: stat_empty drops to 0 only on a data_wr that follows a stat_rd made while stat_empty was 1. A data_wr without that read leaves stat_empty at 1 and sends nothing.
- R7: irq is 1 exactly when stat_empty and ctl_irq_en were both 1 on the previous clock edge.
- R8: While nothing is being shifted out, tx_out is 1.
- R9: While ctl_brk is 1, the line sends back-to-back break characters of all zeros, 10 bits long with ctl_wide=0 and 11 bits with ctl_wide=1.
- R10: After ctl_brk returns to 0, the break in progress completes, then at least one 1 bit is sent before any start bit.
- R11: While ctl_en is 0, tx_oe is 0, tx_out is 1 and stat_empty is 1, taking effect on the next clock edge.
- R12: While ctl_en and ctl_txen are 1, tx_out changes only on a clock edge where baud_tick is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| ctl_en | input | 1 | Module enable; 0 releases the line |
| ctl_txen | input | 1 | Transmitter enable |
| ctl_wide | input | 1 | Character length: 0 selects 8 data bits, 1 selects 9 |
| ctl_xbit | input | 1 | Ninth data bit in 9-bit mode |
| ctl_brk | input | 1 | Send break characters while 1 |
| ctl_irq_en | input | 1 | Interrupt enable for the empty flag |
| stat_rd | input | 1 | Status read strobe (arms the flag clear) |
| data_wr | input | 1 | Data buffer write strobe |
| data_in | input | DATA_W | Byte to send |
| stat_empty | output | 1 | Buffer can accept a byte |
| irq | output | 1 | Interrupt request |
| tx_out | output | 1 | Serial line |
| tx_oe | output | 1 | Line output enable |

## Verification
The hardest situation to reach is a break ending while a data byte is already waiting. The mandatory high bit must then come between the last zero and the start bit. The stimulus raises ctl_brk first, queues a byte with a read-and-write pair while the break runs, and drops ctl_brk partway through the second break. The bench then checks the exact bit-by-bit stream in both character lengths. The preamble length is checked the same way: a byte is queued while the transmitter is held off, and the capture is aligned to the enabling edge.

// File: rtl/uart_brk_pkg.sv
package uart_brk_pkg;
  // What the shift register receives in a given cycle
  typedef enum logic [2:0] {
    LD_NONE,
    LD_PRE,
    LD_BRK,
    LD_MARK,
    LD_DATA
  } load_e;
endpackage

// File: rtl/uart_brk_hostif.sv
module uart_brk_hostif #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              irq_en,
  input  logic              stat_rd,
  input  logic              data_wr,
  input  logic [DATA_W-1:0] data_in,
  input  logic              take,
  output logic [DATA_W-1:0] buf_q,
  output logic              full,
  output logic              empty_q,
  output logic              irq_q
);
  logic armed_q;
  logic empty_n;

  // Next value of the empty flag: module off forces it, a transfer sets it,
  // an armed write clears it.
  always_comb begin
    empty_n = empty_q;
    if (!en)                    empty_n = 1'b1;
    else if (take)              empty_n = 1'b1;
    else if (data_wr && armed_q) empty_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      empty_q <= 1'b1;
      irq_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      empty_q <= empty_n;
      irq_q   <= empty_n & irq_en;
      if (!en)                     armed_q <= 1'b0;
      else if (data_wr)            armed_q <= 1'b0;
      else if (stat_rd && empty_q) armed_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          buf_q <= '0;
    else if (data_wr) buf_q <= data_in;
  end

  assign full = ~empty_q;

  // R6: the flag only falls after an armed write
  p_clear_needs_read_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(empty_q) |-> ($past(armed_q) && $past(data_wr)));

  // R7: no request without the enable
  p_irq_needs_enable_r7: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> $past(irq_en));

  // R11: a disabled module reports an empty buffer
  p_off_reads_empty_r11: assert property (@(posedge clk) disable iff (rst)
    !en |=> empty_q);
endmodule

// File: rtl/uart_brk_shifter.sv
module uart_brk_shifter
  import uart_brk_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              wide,
  input  logic              xbit,
  input  logic              brk,
  input  logic              tick,
  input  logic              full,
  input  logic [DATA_W-1:0] buf_data,
  output logic              take,
  output logic              tx_q
);
  localparam int SR_W  = DATA_W + 3;
  localparam int CNT_W = $clog2(SR_W + 1);

  logic [SR_W-1:0]  sr_q, eff_sr, frame;
  logic [CNT_W-1:0] cnt_q, eff_cnt, flen;
  logic             run_d, mark_q, run_rise;
  load_e            sel;

  assign run_rise = run & ~run_d;

  always_comb begin
    flen = wide ? CNT_W'(SR_W) : CNT_W'(SR_W - 1);
    frame = '1;
    frame[0] = 1'b0;
    frame[DATA_W:1] = buf_data;
    frame[DATA_W+1] = wide ? xbit : 1'b1;

    sel = LD_NONE;
    if (run_rise)            sel = LD_PRE;
    else if (cnt_q == '0) begin
      if (brk)               sel = LD_BRK;
      else if (mark_q)       sel = LD_MARK;
      else if (full)         sel = LD_DATA;
    end

    eff_sr  = sr_q;
    eff_cnt = cnt_q;
    case (sel)
      LD_PRE:  begin eff_sr = '1;    eff_cnt = flen;         end
      LD_BRK:  begin eff_sr = '0;    eff_cnt = flen;         end
      LD_MARK: begin eff_sr = '1;    eff_cnt = CNT_W'(1);    end
      LD_DATA: begin eff_sr = frame; eff_cnt = flen;         end
      default: ;
    endcase
  end

  assign take = run & (sel == LD_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_d  <= 1'b0;
      sr_q   <= '1;
      cnt_q  <= '0;
      mark_q <= 1'b0;
      tx_q   <= 1'b1;
    end else begin
      run_d <= run;
      if (!run) begin
        sr_q   <= '1;
        cnt_q  <= '0;
        mark_q <= 1'b0;
        tx_q   <= 1'b1;
      end else begin
        if (sel == LD_BRK)       mark_q <= 1'b1;
        else if (sel == LD_MARK) mark_q <= 1'b0;
        if (tick) begin
          tx_q  <= (eff_cnt != '0) ? eff_sr[0] : 1'b1;
          sr_q  <= {1'b1, eff_sr[SR_W-1:1]};
          cnt_q <= (eff_cnt != '0) ? eff_cnt - CNT_W'(1) : '0;
        end else begin
          sr_q  <= eff_sr;
          cnt_q <= eff_cnt;
        end
      end
    end
  end

  // R12: bits advance only on the external tick
  p_moves_on_tick_r12: assert property (@(posedge clk) disable iff (rst)
    (run && !tick) |=> $stable(tx_q));

  // R8: a stopped shifter holds the line high and empty
  p_stopped_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !run |=> (tx_q && cnt_q == '0));

  // R3: bit count never exceeds the longest frame
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(SR_W));

  // R10: leaving the post-break state means a high bit is queued or on the line
  p_mark_after_break_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(mark_q) |-> (cnt_q == CNT_W'(1) || tx_q));
endmodule

// File: rtl/uart_brk_tx.sv
module uart_brk_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_tick,
  input  logic              ctl_en,
  input  logic              ctl_txen,
  input  logic              ctl_wide,
  input  logic              ctl_xbit,
  input  logic              ctl_brk,
  input  logic              ctl_irq_en,
  input  logic              stat_rd,
  input  logic              data_wr,
  input  logic [DATA_W-1:0] data_in,
  output logic              stat_empty,
  output logic              irq,
  output logic              tx_out,
  output logic              tx_oe
);
  logic              run;
  logic              take;
  logic              full;
  logic [DATA_W-1:0] buf_q;

  assign run = ctl_en & ctl_txen;

  uart_brk_hostif #(.DATA_W(DATA_W)) host_i (
    .clk     (clk),
    .rst     (rst),
    .en      (ctl_en),
    .irq_en  (ctl_irq_en),
    .stat_rd (stat_rd),
    .data_wr (data_wr),
    .data_in (data_in),
    .take    (take),
    .buf_q   (buf_q),
    .full    (full),
    .empty_q (stat_empty),
    .irq_q   (irq)
  );

  uart_brk_shifter #(.DATA_W(DATA_W)) shift_i (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .wide     (ctl_wide),
    .xbit     (ctl_xbit),
    .brk      (ctl_brk),
    .tick     (baud_tick),
    .full     (full),
    .buf_data (buf_q),
    .take     (take),
    .tx_q     (tx_out)
  );

  always_ff @(posedge clk) begin
    if (rst) tx_oe <= 1'b0;
    else     tx_oe <= ctl_en;
  end

  // R11: disabling releases the pin and idles the line
  p_release_r11: assert property (@(posedge clk) disable iff (rst)
    !ctl_en |=> (!tx_oe && tx_out && stat_empty));
endmodule

// File: tb/uart_brk_tx_tb_top.sv
module uart_brk_tx_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       baud_tick = 1'b0;
  logic       ctl_en = 1'b0, ctl_txen = 1'b0, ctl_wide = 1'b0, ctl_xbit = 1'b0;
  logic       ctl_brk = 1'b0, ctl_irq_en = 1'b0, stat_rd = 1'b0, data_wr = 1'b0;
  logic [7:0] data_in = '0;
  logic       stat_empty, irq, tx_out, tx_oe;

  int total = 0;
  int bad = 0;
  int viol = 0;
  bit finished = 1'b0;
  int tdiv = 0;
  logic cap [0:63];
  logic expb [0:63];

  always #4 clk = ~clk;

  uart_brk_tx #(.DATA_W(8)) dut_i (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .ctl_en(ctl_en),
    .ctl_txen(ctl_txen), .ctl_wide(ctl_wide), .ctl_xbit(ctl_xbit),
    .ctl_brk(ctl_brk), .ctl_irq_en(ctl_irq_en), .stat_rd(stat_rd),
    .data_wr(data_wr), .data_in(data_in), .stat_empty(stat_empty),
    .irq(irq), .tx_out(tx_out), .tx_oe(tx_oe)
  );

  // tick every fourth cycle, driven away from the active edge
  always @(negedge clk) begin
    tdiv = (tdiv + 1) % 4;
    baud_tick = (tdiv == 0);
  end

  // R12 monitor: line changes only after a ticking edge while running
  logic tick_at_edge = 1'b0, run_at_edge = 1'b0, tx_prev = 1'b1;
  always @(posedge clk) begin
    tick_at_edge <= baud_tick;
    run_at_edge  <= ctl_en & ctl_txen & ~rst;
  end
  always @(negedge clk) begin
    if (!rst && run_at_edge && !tick_at_edge && tx_out !== tx_prev) viol++;
    tx_prev = tx_out;
  end

  task automatic chk(input string req, input int act, input int expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic next_bit(output logic b);
    @(posedge clk);
    while (!baud_tick) @(posedge clk);
    #2 b = tx_out;
  endtask

  task automatic cap_raw(input int n);
    logic b;
    for (int i = 0; i < n; i++) begin
      next_bit(b);
      cap[i] = b;
    end
  endtask

  task automatic cap_start(input int n);
    logic b;
    int guard;
    b = 1'b1;
    guard = 0;
    while (b === 1'b1 && guard < 300) begin
      next_bit(b);
      guard++;
    end
    cap[0] = b;
    for (int i = 1; i < n; i++) begin
      next_bit(b);
      cap[i] = b;
    end
  endtask

  task automatic arm_write(input logic [7:0] d);
    @(negedge clk) stat_rd = 1'b1;
    @(negedge clk) begin stat_rd = 1'b0; data_wr = 1'b1; data_in = d; end
    @(negedge clk) data_wr = 1'b0;
  endtask

  // expected frame placed at base; returns its length
  function automatic int mk_frame(input int base, input logic [7:0] d,
                                  input logic b9, input bit w);
    expb[base] = 1'b0;
    for (int i = 0; i < 8; i++) expb[base+1+i] = d[i];
    if (w) begin
      expb[base+9]  = b9;
      expb[base+10] = 1'b1;
      return 11;
    end
    expb[base+9] = 1'b1;
    return 10;
  endfunction

  task automatic send_check(input logic [7:0] d, input logic b9, input bit w);
    int n;
    @(negedge clk) ctl_xbit = b9;
    n = mk_frame(0, d, b9, w);
    fork
      cap_start(n);
      arm_write(d);
    join
    for (int i = 0; i < n; i++)
      chk(w ? "R3 frame bit" : "R2 frame bit", int'(cap[i]), int'(expb[i]));
  endtask

  task automatic break_case(input bit w, input logic [7:0] d);
    int flen, n, k;
    logic dummy;
    flen = w ? 11 : 10;
    @(negedge clk) begin ctl_wide = w; ctl_xbit = 1'b1; end
    @(negedge clk) ctl_brk = 1'b1;
    fork
      cap_raw(2 * flen + 2 + flen);
      begin
        arm_write(d);
        for (int i = 0; i < 14; i++) next_bit(dummy);
        @(negedge clk) ctl_brk = 1'b0;
      end
    join
    for (int i = 0; i < 2 * flen; i++) expb[i] = 1'b0;
    expb[2*flen] = 1'b1;
    n = mk_frame(2 * flen + 1, d, 1'b1, w);
    k = 2 * flen + 1 + n;
    expb[k] = 1'b1;
    for (int i = 0; i <= k; i++) begin
      if (i < 2 * flen)       chk("R9 break bit", int'(cap[i]), int'(expb[i]));
      else if (i == 2 * flen) chk("R10 mark bit", int'(cap[i]), int'(expb[i]));
      else                    chk("R10 frame after break", int'(cap[i]), int'(expb[i]));
    end
  endtask

  initial begin
    logic [7:0] vals [6];
    int n;
    vals = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80};
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 empty", int'(stat_empty), 1);
    chk("R1 tx", int'(tx_out), 1);
    chk("R1 oe", int'(tx_oe), 0);
    chk("R1 irq", int'(irq), 0);

    // R4 preamble: queue a byte with the transmitter held off
    ctl_en = 1'b1;
    @(negedge clk);
    chk("R11 oe on", int'(tx_oe), 1);
    arm_write(8'hA5);
    chk("R6 armed write clears empty", int'(stat_empty), 0);
    @(negedge clk) ctl_txen = 1'b1;
    cap_raw(22);
    for (int i = 0; i < 10; i++) expb[i] = 1'b1;
    n = mk_frame(10, 8'hA5, 1'b0, 1'b0);
    expb[20] = 1'b1;
    expb[21] = 1'b1;
    for (int i = 0; i < 22; i++) begin
      if (i < 10)       chk("R4 preamble bit", int'(cap[i]), int'(expb[i]));
      else if (i < 20)  chk("R2 frame after preamble", int'(cap[i]), int'(expb[i]));
      else              chk("R8 idle high", int'(cap[i]), int'(expb[i]));
    end
    chk("R5 empty after transfer", int'(stat_empty), 1);

    // R6: write without status read
    @(negedge clk) begin data_wr = 1'b1; data_in = 8'h77; end
    @(negedge clk) data_wr = 1'b0;
    @(negedge clk);
    chk("R6 unarmed write keeps empty", int'(stat_empty), 1);
    cap_raw(15);
    for (int i = 0; i < 15; i++) chk("R6 nothing sent", int'(cap[i]), 1);

    // R2/R3 sweep over data values and ninth bit
    for (int v = 0; v < 6; v++) send_check(vals[v], 1'b0, 1'b0);
    @(negedge clk) ctl_wide = 1'b1;
    for (int v = 0; v < 6; v++) begin
      send_check(vals[v], 1'b0, 1'b1);
      send_check(vals[v], 1'b1, 1'b1);
    end

    // R5 back-to-back 9-bit frames
    @(negedge clk) ctl_xbit = 1'b1;
    fork
      cap_start(22);
      begin
        arm_write(8'h96);
        @(negedge clk);
        while (!stat_empty) @(negedge clk);
        ctl_xbit = 1'b0;
        arm_write(8'h69);
      end
    join
    n = mk_frame(0, 8'h96, 1'b1, 1'b1);
    n = mk_frame(11, 8'h69, 1'b0, 1'b1);
    for (int i = 0; i < 22; i++) chk("R5 back-to-back bit", int'(cap[i]), int'(expb[i]));

    // R7 interrupt request
    repeat (8) @(negedge clk);
    ctl_irq_en = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R7 irq with empty", int'(irq), 1);
    ctl_txen = 1'b0;
    @(negedge clk);
    arm_write(8'h11);
    @(negedge clk);
    chk("R6 held byte not empty", int'(stat_empty), 0);
    chk("R7 irq low when full", int'(irq), 0);
    ctl_txen = 1'b1;
    repeat (120) @(negedge clk);
    chk("R5 empty after drain", int'(stat_empty), 1);
    chk("R7 irq after drain", int'(irq), 1);
    ctl_irq_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R7 irq masked", int'(irq), 0);

    // R9/R10 breaks in both lengths
    break_case(1'b0, 8'h3C);
    repeat (20) @(negedge clk);
    break_case(1'b1, 8'hC3);
    repeat (20) @(negedge clk);

    // R11 disable mid-frame
    @(negedge clk) ctl_wide = 1'b0;
    arm_write(8'hF0);
    repeat (24) @(negedge clk);
    chk("R11 oe while enabled", int'(tx_oe), 1);
    ctl_en = 1'b0;
    @(negedge clk);
    chk("R11 oe released", int'(tx_oe), 0);
    chk("R11 tx idle", int'(tx_out), 1);
    chk("R11 empty", int'(stat_empty), 1);
    chk("R12 line moved off tick", viol, 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule